// File: doc/BRIEF.md
# Inter-Core Message Interrupt Controller

This block lets the cores of a multi-core system interrupt one another through a small memory-mapped register file. Each core owns one control word and one status word. To signal another core, a core writes its own control word with the generate bit set, the number of the target core and a 16-bit payload. The target core's status word then shows a pending flag, the number of the sending core and the payload. The target core's level interrupt line stays high until that core writes the acknowledge bit into its own control word.

The bus side is a plain single-cycle 32-bit slave with a byte address, a write strobe and a read strobe. Registers are whole 32-bit words. The bit numbers below are word bit numbers, so the big-endian byte order of the bus does not change any field position. The block has no interrupt inputs. Messages enter only through bus writes. The number of cores is a parameter from 1 to 16.

Top module: `ipi_mailbox`

## Requirements
- R1: After reset every `irq_out` bit is 0, and every status word reads 0.
- R2: A write with bit 30 (generate) set to the control word of an existing core S delivers a message. The destination core D is given by bits 29..16 of the write data and must be below NCORES. After the clock edge of the write, D's status word reads bit 30 = 1, bits 29..16 = S and bits 15..0 = the written bits 15..0, and `irq_out[D]` is 1.
- R3: A write with bit 31 (acknowledge) set to core S's control word clears S's pending flag, so `irq_out[S]` is 0 after the edge. The flags of other cores do not change.
- R4: `irq_out[k]` is a level output. It stays high from the message until core k acknowledges, whatever else happens on the bus.
- R5: A message that reaches a core whose flag is already pending replaces the source and data fields, and the flag stays pending.
- R6: If one write carries both acknowledge and generate, and the generate targets the writing core itself, the generate wins: the flag is pending and the fields hold the new message.
- R7: A generate write whose destination number is NCORES or more changes no state.
- R8: Writes to a status word, and writes to any address whose core index (address bits 7..3) is NCORES or more, change no state.
- R9: Address map: core k's control word is at byte address k*8 and its status word is at k*8+4. Address bit 2 selects status over control, and address bits 1..0 are ignored.
- R10: `bus_rdata` is registered. It shows the addressed word in the cycle after the edge at which `bus_rd` was high, and 0 after any edge at which `bus_rd` was low. Control words read as 0, addresses beyond the last core read as 0, and status bit 31 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid one cycle after the read strobe |
| irq_out | output | NCORES (4) | Per-core level interrupt |

## Verification
A wrong pending flag shows at once on `irq_out`, in the cycle after the write that should have set or cleared it. A wrong source or data field shows only when the bench reads that core's status word. The bench therefore reads the status words often, so a corrupted field is caught within a few operations of the write that caused it. A wrong decode of the destination or of the writer index puts the flag on the wrong line, so the bench compares all interrupt lines after every bus operation.

// File: rtl/ipi_mailbox.sv
module ipi_mailbox #(
  parameter int unsigned NCORES = 4,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  output logic [NCORES-1:0] irq_out
);
  localparam int unsigned IW = ADDR_W - 3;
  localparam int unsigned CW = (NCORES > 1) ? $clog2(NCORES) : 1;

  logic [IW-1:0]     idx;
  logic              in_range, is_stat, ctl_wr, gen_ok;
  logic [13:0]       dst;
  logic [NCORES-1:0] pend, gen_to, ack_to;
  logic [13:0]       src_q [NCORES];
  logic [15:0]       dat_q [NCORES];
  logic [CW-1:0]     sel;

  assign idx      = bus_addr[ADDR_W-1:3];
  assign is_stat  = bus_addr[2];
  assign in_range = 32'(idx) < NCORES;
  assign sel      = CW'(idx);
  assign ctl_wr   = bus_wr && !is_stat && in_range;
  assign dst      = bus_wdata[29:16];
  assign gen_ok   = ctl_wr && bus_wdata[30] && (32'(dst) < NCORES);
  assign irq_out  = pend;

  for (genvar k = 0; k < NCORES; k++) begin : g_core
    assign gen_to[k] = gen_ok && (32'(dst) == k);
    assign ack_to[k] = ctl_wr && bus_wdata[31] && (32'(idx) == k);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend[k]  <= 1'b0;
        src_q[k] <= '0;
        dat_q[k] <= '0;
      end else if (gen_to[k]) begin
        pend[k]  <= 1'b1;
        src_q[k] <= 14'(idx);
        dat_q[k] <= bus_wdata[15:0];
      end else if (ack_to[k]) begin
        pend[k]  <= 1'b0;
      end
    end

    assert_gen_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      gen_to[k] |=> irq_out[k]);
    assert_ack_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ack_to[k] && !gen_to[k] |=> !irq_out[k]);
    assert_level_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !gen_to[k] && !ack_to[k] |=> $stable(irq_out[k]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      bus_rdata <= '0;
    else if (bus_rd && in_range && is_stat)
      bus_rdata <= {1'b0, pend[sel], src_q[sel], dat_q[sel]};
    else
      bus_rdata <= '0;
  end

  assert_rd_oob_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && !in_range |=> bus_rdata == 32'd0);
  assert_rd_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> bus_rdata == 32'd0);
  assert_rd_ctrl_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && !is_stat |=> bus_rdata == 32'd0);
endmodule

// File: tb/sim_ipi_mailbox.sv
module sim_ipi_mailbox;
  localparam int N = 4;
  logic clk = 0, rst_n = 0;
  logic [7:0] bus_addr = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [N-1:0] irq_out;

  int errors = 0, checks = 0;
  logic [N-1:0] m_pend;
  logic [13:0]  m_src [N];
  logic [15:0]  m_dat [N];

  ipi_mailbox #(.NCORES(N), .ADDR_W(8)) u0 (.*);

  always #4 clk = ~clk;

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic logic [31:0] exp_read(logic [7:0] a);
    int i = int'(a[7:3]);
    if (!a[2] || i >= N) return 32'd0;
    return {1'b0, m_pend[i], m_src[i], m_dat[i]};
  endfunction

  function automatic logic [31:0] ctl(bit ack, bit gen, int d, logic [15:0] v);
    return {ack, gen, 14'(d), v};
  endfunction

  task automatic model_wr(logic [7:0] a, logic [31:0] d);
    int i = int'(a[7:3]);
    int t = int'(d[29:16]);
    if (a[2] || i >= N) return;
    if (d[31]) m_pend[i] = 1'b0;
    if (d[30] && t < N) begin
      m_pend[t] = 1'b1; m_src[t] = 14'(i); m_dat[t] = d[15:0];
    end
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, string req);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
    model_wr(a, d);
    chk({req, " irq"}, 32'(irq_out), 32'(m_pend));
  endtask

  task automatic rd(logic [7:0] a, string req);
    logic [31:0] e;
    @(negedge clk);
    bus_addr = a; bus_rd = 1;
    e = exp_read(a);
    @(negedge clk);
    bus_rd = 0;
    chk(req, bus_rdata, e);
    @(negedge clk);
    chk({req, " idle"}, bus_rdata, 32'd0);
  endtask

  task automatic rd_all(string req);
    for (int k = 0; k < N; k++) rd(8'(k*8+4), req);
  endtask

  initial begin
    int unsigned seed = 32'h1234_5678;
    void'($urandom(seed));
    m_pend = '0;
    for (int k = 0; k < N; k++) begin m_src[k] = 0; m_dat[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 irq after reset", 32'(irq_out), 32'd0);
    rd_all("R1 status after reset");

    wr(8'h08, ctl(0, 1, 2, 16'hBEEF), "R2 gen 1->2");
    rd(8'h14, "R2 status core2");
    wr(8'h18, ctl(0, 1, 2, 16'h1111), "R5 overwrite 3->2");
    rd(8'h14, "R5 status core2");
    wr(8'h00, ctl(1, 0, 0, 16'h0), "R4 ack other core");
    chk("R4 irq2 held", 32'(irq_out[2]), 32'd1);
    wr(8'h10, ctl(1, 0, 0, 16'h0), "R3 ack core2");
    rd(8'h14, "R3 status core2");
    wr(8'h08, ctl(1, 1, 1, 16'hA5A5), "R6 ack+gen self");
    rd(8'h0C, "R6 status core1");
    wr(8'h00, ctl(0, 1, N, 16'h7777), "R7 dst out of range");
    wr(8'h00, ctl(0, 1, 14'h3FFF, 16'h7777), "R7 dst max");
    rd_all("R7 no change");
    wr(8'h04, ctl(0, 1, 0, 16'h4444), "R8 write status word");
    wr(8'(N*8), ctl(0, 1, 0, 16'h5555), "R8 write beyond cores");
    rd_all("R8 no change");
    wr(8'h03, ctl(0, 1, 3, 16'h3333), "R9 low bits ignored");
    rd(8'h1F, "R9 status core3 low bits");
    rd(8'h18, "R9 control reads zero");
    rd(8'(N*8+4), "R10 read beyond cores");

    for (int n = 0; n < 300; n++) begin
      logic [7:0] a;
      logic [31:0] d;
      a = 8'($urandom_range(0, N*8 + 15));
      if ($urandom_range(0, 2) == 0) rd(a, "R10 random read");
      else begin
        d = ctl(1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 3) != 0),
                $urandom_range(0, N + 2), 16'($urandom));
        if ($urandom_range(0, 1) == 0) a = {a[7:3], 3'b000};
        wr(a, d, "R2 random write");
      end
    end
    rd_all("R5 final status");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule